// File: doc/BRIEF.md
# Priority Reference Selector with Reversion

This block decides which of up to twelve candidate input references drives one clock generator. Each cycle it looks at a qualified flag, a 4-bit priority and a qualified-duration count for every reference, plus a mode bit, a revertive bit and a software-written manual index. It then produces a registered active index with a valid flag, and an automatically chosen index that software can read back.

In manual mode the active index is whatever software wrote. In automatic mode the best eligible reference is picked. A reference is eligible when it is qualified and its priority is non-zero. The lowest non-zero priority value wins. Ties go to the longer qualified duration, then to the lower index. The revertive bit decides whether a better reference may pre-empt the current choice, or whether the current choice is kept until it drops out. The automatic choice is tracked in both modes, so it is always ready when automatic mode is entered.

Top module: `ref_selector`

## Requirements
- R1: During and directly after reset, active_idx and auto_idx read 0 and active_valid reads 0.
- R2: With auto_mode at 0 and man_idx at most 11, active_idx equals man_idx and active_valid is 1 one clock later. With man_idx 12 or more, active_valid is 0 and active_idx keeps its previous value.
- R3: A priority of 0 excludes a reference from automatic selection. Among eligible references the numerically smallest priority value (1 highest, 15 lowest) is chosen.
- R4: Between eligible references of equal priority, the one with the larger qualified-duration count ranks higher.
- R5: When both priority and duration are equal, the reference with the lower index ranks higher.
- R6: When the current automatic choice stops being qualified, or its priority is set to 0, the next clock selects the best reference that remains eligible.
- R7: With revertive at 1, the best eligible reference replaces the current automatic choice on the next clock.
- R8: With revertive at 0, the current automatic choice is kept for as long as it stays eligible, even when a better reference becomes eligible.
- R9: When no reference is eligible, the automatic choice becomes invalid and its index is held. In automatic mode active_valid goes to 0 and active_idx is held.
- R10: auto_idx tracks the automatic choice in both modes. In automatic mode active_idx and active_valid follow that choice in the same cycle. Every output change appears one clock after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| revertive | input | 1 | 1 = better reference may pre-empt the current one |
| man_idx | input | 4 | Software-written manual reference index |
| prio_tbl | input | 48 | 4-bit priority per reference; reference i at bits [4i+3:4i] |
| qual_vec | input | 12 | Qualified flag per reference; bit i is reference i |
| qual_age | input | 192 | 16-bit qualified-duration count per reference; reference i at bits [16i+15:16i] |
| active_idx | output | 4 | Registered active reference index |
| active_valid | output | 1 | Active index is usable |
| auto_idx | output | 4 | Registered automatic choice, readable by software |

## Verification
The bench targets a cycle in which the current reference drops out at the same time as other references become qualified. In non-revertive mode the selector must then take the best of the newcomers instead of holding. A second case changes the mode on the same edge that the automatic choice moves: the manual index must appear on active_idx while auto_idx takes the new automatic pick. The reverse case returns to automatic mode, and active_idx must then match auto_idx in the same cycle. A reference model in the bench predicts each outcome from the requirements, and the monitor compares it one clock after the stimulus.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int PRIO_W = 4;
  localparam int IDX_W  = 4;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [IDX_W-1:0]  ref_idx_t;

  localparam prio_t PRIO_OFF = '0;
endpackage

// File: rtl/ref_rank_cmp.sv
module ref_rank_cmp
  import refsel_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             inc_valid,
  input  prio_t            inc_prio,
  input  logic [DUR_W-1:0] inc_age,
  input  logic             cha_valid,
  input  prio_t            cha_prio,
  input  logic [DUR_W-1:0] cha_age,
  output logic             cha_wins
);
  logic prio_better;
  logic prio_equal;
  logic age_better;

  always_comb begin
    prio_better = cha_prio < inc_prio;
    prio_equal  = cha_prio == inc_prio;
    age_better  = cha_age > inc_age;
    // strict comparison: a full tie keeps the incumbent (lower index)
    cha_wins    = cha_valid &&
                  (!inc_valid || prio_better || (prio_equal && age_better));
  end
endmodule

// File: rtl/ref_best_pick.sv
module ref_best_pick
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 12,
  parameter int DUR_W    = 16
) (
  input  logic [NUM_REFS*PRIO_W-1:0] prio_tbl,
  input  logic [NUM_REFS-1:0]        qual_vec,
  input  logic [NUM_REFS*DUR_W-1:0]  qual_age,
  output logic [NUM_REFS-1:0]        elig,
  output logic                       best_valid,
  output ref_idx_t                   best_idx
);
  logic             chain_valid [0:NUM_REFS];
  prio_t            chain_prio  [0:NUM_REFS];
  logic [DUR_W-1:0] chain_age   [0:NUM_REFS];
  ref_idx_t         chain_idx   [0:NUM_REFS];

  assign chain_valid[0] = 1'b0;
  assign chain_prio[0]  = '1;
  assign chain_age[0]   = '0;
  assign chain_idx[0]   = '0;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_stage
    prio_t            cand_prio;
    logic [DUR_W-1:0] cand_age;
    logic             cand_ok;
    logic             wins;

    assign cand_prio = prio_tbl[g*PRIO_W +: PRIO_W];
    assign cand_age  = qual_age[g*DUR_W +: DUR_W];
    assign cand_ok   = qual_vec[g] && (cand_prio != PRIO_OFF);
    assign elig[g]   = cand_ok;

    ref_rank_cmp #(.DUR_W(DUR_W)) u_cmp (
      .inc_valid (chain_valid[g]),
      .inc_prio  (chain_prio[g]),
      .inc_age   (chain_age[g]),
      .cha_valid (cand_ok),
      .cha_prio  (cand_prio),
      .cha_age   (cand_age),
      .cha_wins  (wins)
    );

    assign chain_valid[g+1] = wins ? 1'b1            : chain_valid[g];
    assign chain_prio[g+1]  = wins ? cand_prio       : chain_prio[g];
    assign chain_age[g+1]   = wins ? cand_age        : chain_age[g];
    assign chain_idx[g+1]   = wins ? ref_idx_t'(g)   : chain_idx[g];
  end

  assign best_valid = chain_valid[NUM_REFS];
  assign best_idx   = chain_idx[NUM_REFS];
endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_mode,
  input  logic                revertive,
  input  ref_idx_t            man_idx,
  input  logic [NUM_REFS-1:0] elig,
  input  logic                best_valid,
  input  ref_idx_t            best_idx,
  output ref_idx_t            active_idx,
  output logic                active_valid,
  output ref_idx_t            auto_idx
);
  localparam int       PAD_W    = 1 << IDX_W;
  localparam ref_idx_t LAST_IDX = ref_idx_t'(NUM_REFS - 1);

  logic [PAD_W-1:0] elig_pad;
  logic             cur_ok;
  logic             man_ok;

  ref_idx_t auto_idx_q,  auto_idx_n;
  logic     auto_valid_q, auto_valid_n;
  logic     auto_en;
  ref_idx_t act_idx_q,   act_idx_n;
  logic     act_valid_q, act_valid_n;
  logic     act_en;

  assign elig_pad = PAD_W'(elig);
  assign cur_ok   = auto_valid_q && elig_pad[auto_idx_q];
  assign man_ok   = man_idx <= LAST_IDX;

  // automatic choice: next state
  always_comb begin
    auto_idx_n   = auto_idx_q;
    auto_valid_n = auto_valid_q;
    auto_en      = 1'b0;
    if (!best_valid) begin
      auto_valid_n = 1'b0;
      auto_en      = auto_valid_q;
    end else if (!cur_ok || revertive) begin
      auto_idx_n   = best_idx;
      auto_valid_n = 1'b1;
      auto_en      = 1'b1;
    end
  end

  // active output: next state
  always_comb begin
    act_idx_n   = act_idx_q;
    act_valid_n = act_valid_q;
    act_en      = 1'b1;
    if (auto_mode) begin
      act_idx_n   = auto_idx_n;
      act_valid_n = auto_valid_n;
    end else if (man_ok) begin
      act_idx_n   = man_idx;
      act_valid_n = 1'b1;
    end else begin
      act_valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_idx_q   <= '0;
      auto_valid_q <= 1'b0;
    end else if (auto_en) begin
      auto_idx_q   <= auto_idx_n;
      auto_valid_q <= auto_valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_idx_q   <= '0;
      act_valid_q <= 1'b0;
    end else if (act_en) begin
      act_idx_q   <= act_idx_n;
      act_valid_q <= act_valid_n;
    end
  end

  assign active_idx   = act_idx_q;
  assign active_valid = act_valid_q;
  assign auto_idx     = auto_idx_q;

  a_r2_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && man_ok) |=> (active_idx == $past(man_idx) && active_valid));

  a_r6_switch_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && !cur_ok) |=> (auto_valid_q && auto_idx_q == $past(best_idx)));

  a_r7_revert_to_best: assert property (@(posedge clk) disable iff (!rst_n)
    (revertive && best_valid) |=> (auto_idx_q == $past(best_idx)));

  a_r8_hold_current: assert property (@(posedge clk) disable iff (!rst_n)
    (!revertive && cur_ok) |=> (auto_valid_q && $stable(auto_idx_q)));

  a_r9_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (!best_valid) |=> (!auto_valid_q && $stable(auto_idx_q)));

  a_r10_auto_drives_active: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode |=> (active_idx == auto_idx_q && active_valid == auto_valid_q));
endmodule

// File: rtl/ref_selector.sv
module ref_selector
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 12,
  parameter int DUR_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        auto_mode,
  input  logic                        revertive,
  input  logic [IDX_W-1:0]            man_idx,
  input  logic [NUM_REFS*PRIO_W-1:0]  prio_tbl,
  input  logic [NUM_REFS-1:0]         qual_vec,
  input  logic [NUM_REFS*DUR_W-1:0]   qual_age,
  output logic [IDX_W-1:0]            active_idx,
  output logic                        active_valid,
  output logic [IDX_W-1:0]            auto_idx
);
  logic [NUM_REFS-1:0] elig;
  logic                best_valid;
  ref_idx_t            best_idx;

  ref_best_pick #(.NUM_REFS(NUM_REFS), .DUR_W(DUR_W)) u_pick (
    .prio_tbl   (prio_tbl),
    .qual_vec   (qual_vec),
    .qual_age   (qual_age),
    .elig       (elig),
    .best_valid (best_valid),
    .best_idx   (best_idx)
  );

  ref_sel_ctrl #(.NUM_REFS(NUM_REFS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_mode    (auto_mode),
    .revertive    (revertive),
    .man_idx      (man_idx),
    .elig         (elig),
    .best_valid   (best_valid),
    .best_idx     (best_idx),
    .active_idx   (active_idx),
    .active_valid (active_valid),
    .auto_idx     (auto_idx)
  );
endmodule

// File: tb/sim_ref_selector.sv
module sim_ref_selector;
  localparam int N  = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            auto_mode;
  logic            revertive;
  logic [3:0]      man_idx;
  logic [N*4-1:0]  prio_tbl;
  logic [N-1:0]    qual_vec;
  logic [N*DW-1:0] qual_age;
  logic [3:0]      active_idx;
  logic            active_valid;
  logic [3:0]      auto_idx;

  logic [3:0]    pr [N];
  logic [DW-1:0] ag [N];
  logic          ql [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      prio_tbl[i*4 +: 4]   = pr[i];
      qual_age[i*DW +: DW] = ag[i];
      qual_vec[i]          = ql[i];
    end
  end

  ref_selector #(.NUM_REFS(N), .DUR_W(DW)) u0 (
    .clk, .rst_n, .auto_mode, .revertive, .man_idx,
    .prio_tbl, .qual_vec, .qual_age,
    .active_idx, .active_valid, .auto_idx
  );

  typedef struct {
    logic [3:0] a_idx;
    logic       a_vld;
    logic [3:0] au_idx;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] m_aidx, m_act;
  logic       m_avld, m_actv;

  // reference model built from the requirements
  task automatic model_update();
    logic       bv = 0;
    logic [3:0] bi = 0;
    logic [3:0] bp = 0;
    logic [DW-1:0] ba = 0;
    logic cur_ok;
    for (int i = 0; i < N; i++) begin
      if (ql[i] && pr[i] != 0) begin
        if (!bv || pr[i] < bp || (pr[i] == bp && ag[i] > ba)) begin
          bv = 1; bi = 4'(i); bp = pr[i]; ba = ag[i];
        end
      end
    end
    cur_ok = 0;
    if (m_avld && m_aidx < N) cur_ok = ql[m_aidx] && (pr[m_aidx] != 0);
    if (!bv) m_avld = 0;
    else if (!cur_ok || revertive) begin m_aidx = bi; m_avld = 1; end
    if (auto_mode) begin m_act = m_aidx; m_actv = m_avld; end
    else if (man_idx < N) begin m_act = man_idx; m_actv = 1; end
    else m_actv = 0;
  endtask

  // driver: inputs already set by caller at a safe time
  task automatic step(input string tag);
    exp_t e;
    model_update();
    e.a_idx = m_act; e.a_vld = m_actv; e.au_idx = m_aidx; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #8;
  endtask

  // monitor
  always begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (active_idx !== e.a_idx || active_valid !== e.a_vld || auto_idx !== e.au_idx) begin
        fails++;
        $display("FAIL %s: actual idx=%0d vld=%0d auto=%0d expected idx=%0d vld=%0d auto=%0d",
                 e.tag, active_idx, active_valid, auto_idx, e.a_idx, e.a_vld, e.au_idx);
      end
    end
  end

  task automatic check_reset(input string when);
    checks++;
    if (active_idx !== 0 || active_valid !== 0 || auto_idx !== 0) begin
      fails++;
      $display("FAIL R1 %s: actual idx=%0d vld=%0d auto=%0d expected 0 0 0",
               when, active_idx, active_valid, auto_idx);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; auto_mode = 0; revertive = 0; man_idx = 0;
    for (int i = 0; i < N; i++) begin pr[i] = 0; ag[i] = 100; ql[i] = 0; end
    m_aidx = 0; m_avld = 0; m_act = 0; m_actv = 0;
    #45;
    check_reset("in reset");
    @(negedge clk);
    rst_n = 1;
    #2;
    check_reset("after release");
    @(posedge clk);
    #8;

    // R2 manual selection
    man_idx = 5;  step("R2 manual 5");
    man_idx = 11; step("R2 manual 11");
    man_idx = 13; step("R2 out of range held");
    // R10 auto choice tracked while manual
    man_idx = 2; ql[3] = 1; pr[3] = 2; step("R10 auto tracked in manual");

    // automatic, non-revertive
    auto_mode = 1; revertive = 0;
    ql[3] = 0; ql[2] = 1; pr[2] = 0; ql[7] = 1; pr[7] = 4;
    step("R3 masked ref skipped");
    ql[4] = 1; pr[4] = 1; step("R8 non-revertive keeps current");
    revertive = 1; step("R7 revertive pre-empts");
    revertive = 0; ql[4] = 0; step("R6 disqualified switch");
    revertive = 1; ql[8] = 1; pr[8] = 4; ag[8] = 200; step("R4 longer duration wins");
    ag[8] = 100; step("R5 lower index on full tie");
    pr[7] = 0; step("R6 priority masked switch");
    for (int i = 0; i < N; i++) ql[i] = 0;
    step("R9 none eligible holds");
    ql[3] = 1; pr[3] = 15; step("R3 lowest priority still usable");
    revertive = 0; ql[3] = 0; ql[5] = 1; pr[5] = 2; ql[6] = 1; pr[6] = 9;
    step("R6 loss and arrivals same cycle");
    revertive = 1; auto_mode = 0; man_idx = 1; ql[0] = 1; pr[0] = 1;
    step("R10 mode change with auto move");
    auto_mode = 1; step("R10 active follows auto");
    step("R10 steady");

    wait (q.size() == 0);
    @(posedge clk);
    #8;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule